// File: doc/BRIEF.md
# Wrapping Burst Line-Fill Sequencer

This block runs the refill of one cache line after a miss. It takes the missed address, then drives the word address of each beat in wrapping order: it starts at the word that holds the missed data, runs to the end of the line, and wraps to the start of the line. Each beat the bus returns is stored in a line register at its own word slot. The first word that arrives is handed straight back to the requester, and a hit-permit signal goes high so that later accesses that hit can proceed while the rest of the burst is still arriving.

When the fourth beat has arrived, the whole line is presented to the cache array in a single write, together with its line address and a valid flag. A one-cycle completion pulse carries a status code. The code tells apart a clean fill, a fill that failed on one of the later beats, and a fill that failed on the critical beat, which the core must treat as a machine check. Arbitration for the bus happens outside this block.

Top module: `lf_burst_fill`

## Requirements
- R1: Synchronous active-high reset clears `busy`, `fwd_valid`, `line_we` and `done`, and sets `hit_ok` to 1.
- R2: `miss_valid` starts a fill only when `busy` is 0, and `busy` rises in the next cycle. A miss presented while `busy` is 1 is ignored: the beat addresses, line address and line contents of the running fill are unchanged.
- R3: While `busy` is 1, `bus_addr` holds the address of the next beat. Beat i (i = 0..3) uses word index (c + i) mod 4 in address bits [3:2], where c is the missed word index taken from `miss_addr[3:2]`. Bits [31:4] are the missed line and bits [1:0] are 0.
- R4: In the cycle after beat 0 is accepted, `fwd_valid` is 1 for exactly one cycle and `fwd_data` equals the data of that beat.
- R5: `hit_ok` is 0 from the cycle after a miss is accepted up to and including the cycle in which beat 0 is accepted, and it is 1 at all other times.
- R6: In the cycle after beat 3 is accepted, `line_we` is 1 for one cycle, `line_addr` equals the missed address with bits [3:0] cleared, and word slot k (`line_data[32k+31:32k]`) holds the beat whose word index was k.
- R7: A cycle with `busy` 1 and `bus_beat_valid` 0 neither stores data nor advances `bus_addr`.
- R8: `done` pulses for one cycle together with `line_we`. `done_status` is 2'b00 for a clean fill, 2'b01 when only beats 1..3 reported `bus_err`, and 2'b10 when beat 0 reported `bus_err`. The 2'b10 code takes priority over 2'b01.
- R9: After a beat error the remaining beats are still accepted and the fill still ends after four beats. `line_valid` is 1 only when no beat reported `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | Request to start a line fill |
| miss_addr | input | 32 | Byte address of the missed access |
| busy | output | 1 | A fill is in progress |
| bus_addr | output | 32 | Word address of the next expected beat |
| bus_beat_valid | input | 1 | Bus returns a beat this cycle |
| bus_data | input | 32 | Beat data |
| bus_err | input | 1 | The current beat failed |
| fwd_valid | output | 1 | Critical word forwarded this cycle |
| fwd_data | output | 32 | Forwarded critical word |
| hit_ok | output | 1 | Hits may be served |
| line_we | output | 1 | Write the assembled line into the array |
| line_addr | output | 32 | Line-aligned address for the write |
| line_data | output | 128 | Assembled line, word k in bits [32k+31:32k] |
| line_valid | output | 1 | Written line may be marked valid |
| done | output | 1 | Fill-complete pulse |
| done_status | output | 2 | Fill result code |

## Verification
The critical forward and a stray new miss can fall on nearby cycles, and the final beat's error and the completion status always fall in the same cycle. The sweep covers every starting word index, every single-beat error position and the clean case, with and without a stall beat. During the stall it presents a conflicting miss, and it judges from the beat addresses and the written line that this miss left the running fill untouched. For an error on beat 3, the status must already reflect the error of that same cycle, and the written line must come out invalid.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic [1:0] {
    FILL_OK       = 2'b00,
    FILL_LATE_ERR = 2'b01,
    FILL_CRIT_ERR = 2'b10
  } fill_stat_e;
endpackage

// File: rtl/lf_order.sv
module lf_order #(
  parameter int WIDX_W = 2
) (
  input  logic [WIDX_W-1:0] crit_i,
  input  logic [WIDX_W-1:0] beat_i,
  output logic [WIDX_W-1:0] cur_slot_o,
  output logic [WIDX_W-1:0] nxt_slot_o
);
  // wrap comes from truncation to WIDX_W bits
  assign cur_slot_o = crit_i + beat_i;
  assign nxt_slot_o = crit_i + beat_i + WIDX_W'(1);
endmodule

// File: rtl/lf_line_buf.sv
module lf_line_buf #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int WIDX_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [WIDX_W-1:0]       slot,
  input  logic [WORD_W-1:0]       wdata,
  output logic [WORDS*WORD_W-1:0] line_o
);
  logic [WORDS-1:0] slot_we;

  for (genvar k = 0; k < WORDS; k++) begin : g_slot
    logic [WORD_W-1:0] word_q;
    assign slot_we[k] = wr_en && (slot == WIDX_W'(k));
    always_ff @(posedge clk) begin
      if (slot_we[k]) word_q <= wdata;
    end
    assign line_o[k*WORD_W +: WORD_W] = word_q;
  end

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_we)); // R6
endmodule

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import lf_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int WIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [WIDX_W-1:0] miss_widx,
  input  logic              bus_beat_valid,
  input  logic              bus_err,
  output logic              accept_o,
  output logic              beat_acc_o,
  output logic              first_beat_o,
  output logic              busy_o,
  output logic [WIDX_W-1:0] beat_o,
  output logic [WIDX_W-1:0] crit_o,
  output logic              hit_ok_o,
  output logic              fwd_valid_o,
  output logic              line_we_o,
  output logic              line_valid_o,
  output logic              done_o,
  output logic [1:0]        status_o
);
  localparam logic [WIDX_W-1:0] LAST_BEAT = WIDX_W'(WORDS - 1);

  logic              busy_q, hit_ok_q, fwd_q, we_q, done_q, lvalid_q;
  logic              err_crit_q, err_late_q;
  logic [WIDX_W-1:0] beat_q, crit_q;
  fill_stat_e        status_q;
  logic              accept, beat_acc, first_beat, last_beat;
  logic              any_crit, any_late;

  assign accept     = miss_valid && !busy_q;
  assign beat_acc   = bus_beat_valid && busy_q;
  assign first_beat = beat_acc && (beat_q == '0);
  assign last_beat  = beat_acc && (beat_q == LAST_BEAT);
  assign any_crit   = err_crit_q || (first_beat && bus_err);
  assign any_late   = err_late_q || (beat_acc && !first_beat && bus_err);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      beat_q     <= '0;
      crit_q     <= '0;
      hit_ok_q   <= 1'b1;
      fwd_q      <= 1'b0;
      we_q       <= 1'b0;
      done_q     <= 1'b0;
      lvalid_q   <= 1'b0;
      err_crit_q <= 1'b0;
      err_late_q <= 1'b0;
      status_q   <= FILL_OK;
    end else begin
      fwd_q  <= first_beat;
      we_q   <= last_beat;
      done_q <= last_beat;
      if (accept) begin
        busy_q     <= 1'b1;
        beat_q     <= '0;
        crit_q     <= miss_widx;
        hit_ok_q   <= 1'b0;
        err_crit_q <= 1'b0;
        err_late_q <= 1'b0;
      end
      if (beat_acc) begin
        beat_q <= beat_q + WIDX_W'(1);
        if (first_beat) hit_ok_q <= 1'b1;
        if (bus_err) begin
          if (first_beat) err_crit_q <= 1'b1;
          else            err_late_q <= 1'b1;
        end
      end
      if (last_beat) begin
        busy_q   <= 1'b0;
        lvalid_q <= !(any_crit || any_late);
        if (any_crit)      status_q <= FILL_CRIT_ERR;
        else if (any_late) status_q <= FILL_LATE_ERR;
        else               status_q <= FILL_OK;
      end
    end
  end

  assign accept_o     = accept;
  assign beat_acc_o   = beat_acc;
  assign first_beat_o = first_beat;
  assign busy_o       = busy_q;
  assign beat_o       = beat_q;
  assign crit_o       = crit_q;
  assign hit_ok_o     = hit_ok_q;
  assign fwd_valid_o  = fwd_q;
  assign line_we_o    = we_q;
  assign line_valid_o = lvalid_q;
  assign done_o       = done_q;
  assign status_o     = status_q;

  AST_HIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> hit_ok_q); // R5
  AST_ACCEPT_BLOCKS_HITS: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy_q && !hit_ok_q); // R2
  AST_FWD_OPENS_HITS: assert property (@(posedge clk) disable iff (rst)
    fwd_q |-> hit_ok_q); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q && we_q); // R8
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> status_q != 2'b11); // R8
  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (lvalid_q == (status_q == FILL_OK))); // R9
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    busy_q && !bus_beat_valid |=> $stable(beat_q)); // R7
endmodule

// File: rtl/lf_burst_fill.sv
module lf_burst_fill #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    miss_valid,
  input  logic [ADDR_W-1:0]       miss_addr,
  output logic                    busy,
  output logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_beat_valid,
  input  logic [WORD_W-1:0]       bus_data,
  input  logic                    bus_err,
  output logic                    fwd_valid,
  output logic [WORD_W-1:0]       fwd_data,
  output logic                    hit_ok,
  output logic                    line_we,
  output logic [ADDR_W-1:0]       line_addr,
  output logic [WORDS*WORD_W-1:0] line_data,
  output logic                    line_valid,
  output logic                    done,
  output logic [1:0]              done_status
);
  localparam int BYTE_OFF = $clog2(WORD_W / 8);
  localparam int WIDX_W   = $clog2(WORDS);
  localparam int LINE_LSB = BYTE_OFF + WIDX_W;
  localparam int TAG_W    = ADDR_W - LINE_LSB;

  logic              accept, beat_acc, first_beat;
  logic [WIDX_W-1:0] beat, crit, cur_slot, nxt_slot;
  logic [TAG_W-1:0]  line_tag_q;
  logic [ADDR_W-1:0] bus_addr_q;
  logic [WORD_W-1:0] fwd_data_q;

  lf_ctrl #(.WORDS(WORDS), .WIDX_W(WIDX_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .miss_valid    (miss_valid),
    .miss_widx     (miss_addr[LINE_LSB-1:BYTE_OFF]),
    .bus_beat_valid(bus_beat_valid),
    .bus_err       (bus_err),
    .accept_o      (accept),
    .beat_acc_o    (beat_acc),
    .first_beat_o  (first_beat),
    .busy_o        (busy),
    .beat_o        (beat),
    .crit_o        (crit),
    .hit_ok_o      (hit_ok),
    .fwd_valid_o   (fwd_valid),
    .line_we_o     (line_we),
    .line_valid_o  (line_valid),
    .done_o        (done),
    .status_o      (done_status)
  );

  lf_order #(.WIDX_W(WIDX_W)) u_order (
    .crit_i    (crit),
    .beat_i    (beat),
    .cur_slot_o(cur_slot),
    .nxt_slot_o(nxt_slot)
  );

  lf_line_buf #(.WORDS(WORDS), .WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_buf (
    .clk   (clk),
    .rst   (rst),
    .wr_en (beat_acc),
    .slot  (cur_slot),
    .wdata (bus_data),
    .line_o(line_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_tag_q <= '0;
      bus_addr_q <= '0;
      fwd_data_q <= '0;
    end else if (accept) begin
      line_tag_q <= miss_addr[ADDR_W-1:LINE_LSB];
      bus_addr_q <= {miss_addr[ADDR_W-1:LINE_LSB], miss_addr[LINE_LSB-1:BYTE_OFF],
                     {BYTE_OFF{1'b0}}};
    end else if (beat_acc) begin
      bus_addr_q <= {line_tag_q, nxt_slot, {BYTE_OFF{1'b0}}};
      if (first_beat) fwd_data_q <= bus_data;
    end
  end

  assign bus_addr  = bus_addr_q;
  assign fwd_data  = fwd_data_q;
  assign line_addr = {line_tag_q, {LINE_LSB{1'b0}}};

  AST_ADDR_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    busy |-> bus_addr[ADDR_W-1:LINE_LSB] == line_addr[ADDR_W-1:LINE_LSB]); // R3
  AST_ADDR_STALL: assert property (@(posedge clk) disable iff (rst)
    busy && !bus_beat_valid && !done |=> $stable(bus_addr)); // R7
endmodule

// File: tb/sim_lf_burst_fill.sv
module sim_lf_burst_fill;
  logic         clk = 1'b0;
  logic         rst;
  logic         miss_valid;
  logic [31:0]  miss_addr;
  logic         busy;
  logic [31:0]  bus_addr;
  logic         bus_beat_valid;
  logic [31:0]  bus_data;
  logic         bus_err;
  logic         fwd_valid;
  logic [31:0]  fwd_data;
  logic         hit_ok;
  logic         line_we;
  logic [31:0]  line_addr;
  logic [127:0] line_data;
  logic         line_valid;
  logic         done;
  logic [1:0]   done_status;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lf_burst_fill u0 (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .busy(busy), .bus_addr(bus_addr), .bus_beat_valid(bus_beat_valid),
    .bus_data(bus_data), .bus_err(bus_err), .fwd_valid(fwd_valid),
    .fwd_data(fwd_data), .hit_ok(hit_ok), .line_we(line_we),
    .line_addr(line_addr), .line_data(line_data), .line_valid(line_valid),
    .done(done), .done_status(done_status)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [27:0] tag, input int idx);
    return 32'hC000_0000 ^ {tag[19:0], 12'h000} ^ (32'h1111 * (idx + 1));
  endfunction

  // one complete fill; errpos 0 = clean, 1..4 = beat errpos-1 fails
  task automatic run_fill(input logic [27:0] tag, input int c, input int errpos, input bit gap);
    logic [1:0] exp_st;
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = {tag, c[1:0], 2'(c + 1)};
    @(negedge clk);
    miss_valid = 1'b0;
    chk("R2 busy after accept", busy, 1);
    chk("R5 hit_ok low while critical pending", hit_ok, 0);
    for (int i = 0; i < 4; i++) begin
      if (gap && i == 1) begin
        miss_valid = 1'b1;
        miss_addr  = {tag ^ 28'h55, 2'(c + 2), 2'b00};
        @(negedge clk);
        miss_valid = 1'b0;
        chk("R7 R2 stall keeps address", bus_addr, {tag, 2'(c + i), 2'b00});
      end
      chk("R3 beat address", bus_addr, {tag, 2'(c + i), 2'b00});
      bus_beat_valid = 1'b1;
      bus_data       = word_of(tag, (c + i) % 4);
      bus_err        = (errpos == i + 1);
      @(negedge clk);
      bus_beat_valid = 1'b0;
      bus_err        = 1'b0;
      if (i == 0) begin
        chk("R4 forward pulse", fwd_valid, 1);
        chk("R4 forward data", fwd_data, word_of(tag, c));
        chk("R5 hit_ok after critical", hit_ok, 1);
      end else begin
        chk("R4 forward single cycle", fwd_valid, 0);
      end
      if (i < 3) begin
        chk("R6 no early line write", line_we, 0);
        chk("R9 still busy after beat", busy, 1);
      end
    end
    exp_st = (errpos == 1) ? 2'b10 : (errpos > 1) ? 2'b01 : 2'b00;
    chk("R6 line write", line_we, 1);
    chk("R8 done pulse", done, 1);
    chk("R8 status", done_status, exp_st);
    chk("R9 line valid", line_valid, errpos == 0);
    chk("R6 line address", line_addr, {tag, 4'h0});
    for (int k = 0; k < 4; k++)
      chk("R6 slot data", line_data[k*32 +: 32], word_of(tag, k));
    chk("R9 idle after four beats", busy, 0);
    chk("R5 hit_ok idle", hit_ok, 1);
    @(negedge clk);
    chk("R6 write single cycle", line_we, 0);
    chk("R8 done single cycle", done, 0);
  endtask

  initial begin
    rst = 1'b1;
    miss_valid = 1'b0;
    miss_addr = '0;
    bus_beat_valid = 1'b0;
    bus_data = '0;
    bus_err = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 busy", busy, 0);
    chk("R1 hit_ok", hit_ok, 1);
    chk("R1 line_we", line_we, 0);
    chk("R1 done", done, 0);
    chk("R1 fwd_valid", fwd_valid, 0);
    for (int g = 0; g < 2; g++)
      for (int e = 0; e < 5; e++)
        for (int c = 0; c < 4; c++)
          run_fill(28'h00A_0000 + 28'(g * 97 + e * 13 + c), c, e, g[0]);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected <= 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule